// File: doc/BRIEF.md
# Boolean Bit Processing Unit

This unit carries out the single-bit instructions of an 8-bit control CPU. It uses the carry flag as a one-bit accumulator. Each operation names an 8-bit bit address. The unit turns that address into a byte address in bit-addressable storage. Low bit addresses fold onto a sixteen-byte window of internal RAM. High bit addresses fold onto special-function-register bytes whose address is a multiple of eight.

The unit reads the selected byte over a combinational read port. Storage supplies two views of that byte: the sampled value and the written latch value. The unit then works out the new carry, the branch decision and any byte write back to storage. A write always covers the whole byte and carries a one-hot mask, so it is a read-modify-write in one operation cycle. All results are registered and appear on the clock edge that accepts the operation. The CPU core keeps the carry itself, so the unit takes the current carry in and returns a carry value with a write strobe.

Instruction fetch, branch target arithmetic and the storage arrays sit outside the unit.

Top module: `bitop_unit`

## Requirements
- R1: A bit address below 0x80 reads byte 0x20 plus bit_addr[6:3] on rd_addr, and bit_addr[2:0] selects the bit inside that byte.
- R2: A bit address of 0x80 or above reads byte {bit_addr[7:3],3'b000} on rd_addr, and bit_addr[2:0] selects the bit inside that byte.
- R3: An operation accepted with op_valid high produces its results on the next clock edge, with done high for exactly that one cycle. Any write has exactly one wr_mask bit set, at the bit index, and the other bits of wr_data equal the byte read.
- R4: Code 4 sets the addressed bit, code 5 clears it and code 6 inverts it. Each of these writes the byte back and leaves the carry alone.
- R5: Code 1 sets the carry, code 2 clears it and code 3 inverts cy_in. These raise cy_we and never write storage.
- R6: Code 7 copies the addressed bit into the carry without writing storage. Code 8 writes cy_in into the addressed bit and leaves the carry alone.
- R7: Codes 9 and 11 give the carry as cy_in AND bit and cy_in OR bit. Codes 10 and 12 give the carry as cy_in AND NOT bit and cy_in OR NOT bit. None of the four writes storage.
- R8: Code 13 raises br_taken when the bit is 1, and code 14 raises it when the bit is 0. Neither code writes storage or the carry.
- R9: Code 15 with the bit at 1 raises br_taken and writes the bit back as 0. With the bit at 0 it neither branches nor writes.
- R10: Codes 4, 5, 6, 8 and 15 take their byte from rd_latch when they address a port byte. Port bytes are the register bytes whose row bit_addr[6:3] is set in PORT_ROWS; by default these are rows 0, 2, 4 and 6, the bytes 0x80, 0x90, 0xA0 and 0xB0. Every other case takes its byte from rd_byte.
- R11: While rst_n is low, done, wr_en, cy_we, br_taken, wr_mask and wr_data are all 0.
- R12: Code 0 completes with done high and nothing else raised. With op_valid low, no done, wr_en, cy_we or br_taken appears, whatever op_code holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept the operation this cycle |
| op_code | input | 4 | Operation select, codes as in the requirements |
| bit_addr | input | 8 | Bit address |
| cy_in | input | 1 | Current carry flag |
| rd_addr | output | 8 | Byte address toward storage (combinational) |
| rd_byte | input | 8 | Sampled value of the byte at rd_addr |
| rd_latch | input | 8 | Written latch value of the byte at rd_addr |
| done | output | 1 | Operation result valid |
| wr_en | output | 1 | Storage write strobe |
| wr_addr | output | 8 | Byte address of the write |
| wr_data | output | 8 | Full byte to write |
| wr_mask | output | 8 | One-hot mask of the changed bit |
| cy_we | output | 1 | Carry write strobe |
| cy_out | output | 1 | New carry value |
| br_taken | output | 1 | Branch decision |

## Verification
On every cycle the assertions check these points. A write has a single mask bit and changes no other bit of the byte that was read. A write lands only inside the RAM window or on an 8-aligned register byte. Carry and storage are never written together. done follows op_valid by one edge. The bit-test branches never write, and the test-and-clear branch writes exactly when it branches. The value of the carry and of the bit, the exact address fold, and the choice between latch and sampled data show up only in the bench's sweep. That sweep covers every bit address against every operation code, with both carry values, and compares each result with arithmetic restated in the bench.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int BW    = 8;                 // storage byte width
  localparam int IW    = $clog2(BW);        // bit index width
  localparam int AW    = 8;                 // bit address width
  localparam int ROWW  = AW - 1 - IW;       // row field width below the region bit
  localparam int ROWS  = 2 ** ROWW;         // bytes per region

  typedef enum logic [3:0] {
    BOP_NOP      = 4'd0,
    BOP_SET_C    = 4'd1,
    BOP_CLR_C    = 4'd2,
    BOP_CPL_C    = 4'd3,
    BOP_SET_B    = 4'd4,
    BOP_CLR_B    = 4'd5,
    BOP_CPL_B    = 4'd6,
    BOP_LD_C     = 4'd7,
    BOP_ST_C     = 4'd8,
    BOP_AND_C    = 4'd9,
    BOP_ANDN_C   = 4'd10,
    BOP_OR_C     = 4'd11,
    BOP_ORN_C    = 4'd12,
    BOP_JSET     = 4'd13,
    BOP_JCLR     = 4'd14,
    BOP_JSET_CLR = 4'd15
  } bop_e;

  typedef struct packed {
    logic          wr_en;
    logic [BW-1:0] wr_data;
    logic [BW-1:0] wr_mask;
    logic          cy_we;
    logic          cy_val;
    logic          br;
  } bop_res_t;

  function automatic logic [BW-1:0] bit_onehot(input logic [IW-1:0] idx);
    logic [BW-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [BW-1:0] put_bit(input logic [BW-1:0] src,
                                            input logic [IW-1:0] idx,
                                            input logic          val);
    logic [BW-1:0] r;
    r = src;
    r[idx] = val;
    return r;
  endfunction

  // operations that write a byte back and therefore read the latch of a port
  function automatic logic is_rmw(input bop_e op);
    return (op == BOP_SET_B) || (op == BOP_CLR_B) || (op == BOP_CPL_B) ||
           (op == BOP_ST_C)  || (op == BOP_JSET_CLR);
  endfunction

  function automatic logic carry_logic(input bop_e op, input logic cy,
                                       input logic b);
    logic r;
    case (op)
      BOP_AND_C:  r = cy & b;
      BOP_ANDN_C: r = cy & ~b;
      BOP_OR_C:   r = cy | b;
      BOP_ORN_C:  r = cy | ~b;
      default:    r = cy;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bitop_addr_map.sv
module bitop_addr_map
  import bitop_pkg::*;
#(
  parameter logic [BW-1:0]   RAM_BASE  = 8'h20,
  parameter logic [ROWS-1:0] PORT_ROWS = 16'h0055
) (
  input  logic [AW-1:0] bit_addr,
  input  bop_e          op,
  output logic [BW-1:0] byte_addr,
  output logic [IW-1:0] bit_idx,
  output logic          in_sfr,
  output logic          use_latch
);

  logic [ROWW-1:0] row;
  logic [ROWS-1:0] row_hit;
  logic            port_row;

  assign row     = bit_addr[AW-2:IW];
  assign bit_idx = bit_addr[IW-1:0];
  assign in_sfr  = bit_addr[AW-1];

  // one comparator per register row; a row is a port only if PORT_ROWS says so
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    if (PORT_ROWS[g]) begin : g_port
      assign row_hit[g] = (row == ROWW'(g));
    end else begin : g_plain
      assign row_hit[g] = 1'b0;
    end
  end

  assign port_row = |row_hit;

  always_comb begin
    if (in_sfr) begin
      byte_addr = {bit_addr[AW-1:IW], {IW{1'b0}}};
    end else begin
      byte_addr = RAM_BASE + BW'(row);
    end
  end

  assign use_latch = in_sfr && port_row && is_rmw(op);

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
  import bitop_pkg::*;
(
  input  bop_e          op,
  input  logic [IW-1:0] bit_idx,
  input  logic [BW-1:0] src_byte,
  input  logic          cy_in,
  output bop_res_t      res
);

  logic          bv;
  logic [BW-1:0] mask;

  assign bv   = src_byte[bit_idx];
  assign mask = bit_onehot(bit_idx);

  always_comb begin
    res = '0;
    case (op)
      BOP_SET_C: begin
        res.cy_we  = 1'b1;
        res.cy_val = 1'b1;
      end
      BOP_CLR_C: begin
        res.cy_we  = 1'b1;
        res.cy_val = 1'b0;
      end
      BOP_CPL_C: begin
        res.cy_we  = 1'b1;
        res.cy_val = ~cy_in;
      end
      BOP_SET_B: begin
        res.wr_en   = 1'b1;
        res.wr_data = put_bit(src_byte, bit_idx, 1'b1);
      end
      BOP_CLR_B: begin
        res.wr_en   = 1'b1;
        res.wr_data = put_bit(src_byte, bit_idx, 1'b0);
      end
      BOP_CPL_B: begin
        res.wr_en   = 1'b1;
        res.wr_data = put_bit(src_byte, bit_idx, ~bv);
      end
      BOP_LD_C: begin
        res.cy_we  = 1'b1;
        res.cy_val = bv;
      end
      BOP_ST_C: begin
        res.wr_en   = 1'b1;
        res.wr_data = put_bit(src_byte, bit_idx, cy_in);
      end
      BOP_AND_C, BOP_ANDN_C, BOP_OR_C, BOP_ORN_C: begin
        res.cy_we  = 1'b1;
        res.cy_val = carry_logic(op, cy_in, bv);
      end
      BOP_JSET: res.br = bv;
      BOP_JCLR: res.br = ~bv;
      BOP_JSET_CLR: begin
        res.br      = bv;
        res.wr_en   = bv;
        res.wr_data = bv ? put_bit(src_byte, bit_idx, 1'b0) : '0;
      end
      default: res = '0;
    endcase
    res.wr_mask = res.wr_en ? mask : '0;
  end

endmodule

// File: rtl/bitop_outreg.sv
module bitop_outreg
  import bitop_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  bop_res_t      res,
  input  logic [BW-1:0] byte_addr,
  output logic          done,
  output logic          wr_en,
  output logic [BW-1:0] wr_addr,
  output logic [BW-1:0] wr_data,
  output logic [BW-1:0] wr_mask,
  output logic          cy_we,
  output logic          cy_out,
  output logic          br_taken
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_mask  <= '0;
      cy_we    <= 1'b0;
      cy_out   <= 1'b0;
      br_taken <= 1'b0;
    end else if (take) begin
      done     <= 1'b1;
      wr_en    <= res.wr_en;
      wr_addr  <= byte_addr;
      wr_data  <= res.wr_data;
      wr_mask  <= res.wr_mask;
      cy_we    <= res.cy_we;
      cy_out   <= res.cy_val;
      br_taken <= res.br;
    end else begin
      done     <= 1'b0;
      wr_en    <= 1'b0;
      wr_mask  <= '0;
      cy_we    <= 1'b0;
      br_taken <= 1'b0;
    end
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter logic [BW-1:0]   RAM_BASE  = 8'h20,
  parameter logic [ROWS-1:0] PORT_ROWS = 16'h0055
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [AW-1:0] bit_addr,
  input  logic          cy_in,
  output logic [BW-1:0] rd_addr,
  input  logic [BW-1:0] rd_byte,
  input  logic [BW-1:0] rd_latch,
  output logic          done,
  output logic          wr_en,
  output logic [BW-1:0] wr_addr,
  output logic [BW-1:0] wr_data,
  output logic [BW-1:0] wr_mask,
  output logic          cy_we,
  output logic          cy_out,
  output logic          br_taken
);

  bop_e          op;
  logic [BW-1:0] byte_addr;
  logic [IW-1:0] bit_idx;
  logic          in_sfr;
  logic          use_latch;
  logic [BW-1:0] sel_byte;   // byte the operation works on, seen by the checker
  bop_res_t      res;

  assign op = bop_e'(op_code);

  bitop_addr_map #(
    .RAM_BASE (RAM_BASE),
    .PORT_ROWS(PORT_ROWS)
  ) u_map (
    .bit_addr (bit_addr),
    .op       (op),
    .byte_addr(byte_addr),
    .bit_idx  (bit_idx),
    .in_sfr   (in_sfr),
    .use_latch(use_latch)
  );

  assign rd_addr  = byte_addr;
  assign sel_byte = use_latch ? rd_latch : rd_byte;

  bitop_exec u_exec (
    .op      (op),
    .bit_idx (bit_idx),
    .src_byte(sel_byte),
    .cy_in   (cy_in),
    .res     (res)
  );

  bitop_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (op_valid),
    .res      (res),
    .byte_addr(byte_addr),
    .done     (done),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .cy_we    (cy_we),
    .cy_out   (cy_out),
    .br_taken (br_taken)
  );

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter logic [7:0] RAM_BASE = 8'h20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic [7:0] sel_byte,
  input logic       done,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] wr_mask,
  input logic       cy_we,
  input logic       br_taken
);

  p_onehot_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_mask) == 1));

  p_keep_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (((wr_data ^ $past(sel_byte)) & ~wr_mask) == 8'h00));

  p_done_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid) |-> done);

  p_no_stray_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> (!done && !wr_en && !cy_we && !br_taken));

  p_wr_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_addr >= RAM_BASE && wr_addr < RAM_BASE + 8'd16) ||
               (wr_addr[7] && wr_addr[2:0] == 3'b000)));

  p_carry_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cy_we));

  p_test_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(op_code) == 4'd13 || $past(op_code) == 4'd14))
      |-> (!wr_en && !cy_we));

  p_jbc_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(op_code) == 4'd15) |-> (wr_en == br_taken));

  p_branch_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (done && $past(op_code) >= 4'd13));

endmodule

bind bitop_unit bitop_unit_chk #(.RAM_BASE(RAM_BASE)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_valid(op_valid),
  .op_code (op_code),
  .sel_byte(sel_byte),
  .done    (done),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .wr_mask (wr_mask),
  .cy_we   (cy_we),
  .br_taken(br_taken)
);

// File: tb/test_bitop_unit.sv
`timescale 1ns/1ps
module test_bitop_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] bit_addr = 8'd0;
  logic       cy_in = 1'b0;
  logic [7:0] rd_addr;
  logic [7:0] rd_byte = 8'd0;
  logic [7:0] rd_latch = 8'd0;
  logic       done, wr_en, cy_we, cy_out, br_taken;
  logic [7:0] wr_addr, wr_data, wr_mask;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [15:0] PORTS = 16'h0055;

  always #10 clk = ~clk;   // 50 MHz

  bitop_unit i_bitop_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bit_addr(bit_addr), .cy_in(cy_in), .rd_addr(rd_addr),
    .rd_byte(rd_byte), .rd_latch(rd_latch), .done(done), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .cy_we(cy_we), .cy_out(cy_out), .br_taken(br_taken)
  );

  function automatic string tag_of(input int op);
    if (op == 0) return "R12";
    if (op <= 3) return "R5";
    if (op <= 6) return "R4";
    if (op <= 8) return "R6";
    if (op <= 12) return "R7";
    if (op <= 14) return "R8";
    return "R9";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one operation with results predicted from the requirements
  task automatic run_op(input int op, input int a, input bit cy,
                        input logic [7:0] pin, input logic [7:0] lat);
    logic [7:0] e_addr, src, m, e_data;
    bit port, rmw, b, e_wr, e_cyw, e_cyv, e_br;
    string tg;
    e_addr = (a < 128) ? 8'(32 + a / 8) : 8'(a - a % 8);
    port   = (a >= 128) && PORTS[(a / 8) % 16];
    rmw    = (op == 4 || op == 5 || op == 6 || op == 8 || op == 15);
    src    = (port && rmw) ? lat : pin;
    b      = src[a % 8];
    m      = 8'(1 << (a % 8));
    e_wr = 0; e_cyw = 0; e_cyv = 0; e_br = 0; e_data = 8'h00;
    case (op)
      1: begin e_cyw = 1; e_cyv = 1; end
      2: begin e_cyw = 1; e_cyv = 0; end
      3: begin e_cyw = 1; e_cyv = !cy; end
      4: begin e_wr = 1; e_data = src | m; end
      5: begin e_wr = 1; e_data = src & ~m; end
      6: begin e_wr = 1; e_data = src ^ m; end
      7: begin e_cyw = 1; e_cyv = b; end
      8: begin e_wr = 1; e_data = (src & ~m) | (cy ? m : 8'h00); end
      9: begin e_cyw = 1; e_cyv = cy && b; end
      10: begin e_cyw = 1; e_cyv = cy && !b; end
      11: begin e_cyw = 1; e_cyv = cy || b; end
      12: begin e_cyw = 1; e_cyv = cy || !b; end
      13: e_br = b;
      14: e_br = !b;
      15: begin e_br = b; e_wr = b; e_data = src & ~m; end
      default: ;
    endcase
    tg = tag_of(op);
    if (port && rmw) tg = {tg, "/R10"};

    @(negedge clk);
    op_code = 4'(op); bit_addr = 8'(a); cy_in = cy;
    rd_byte = pin; rd_latch = lat; op_valid = 1'b1;
    #1;
    check(rd_addr == e_addr, (a < 128) ? "R1" : "R2", "rd_addr", rd_addr, e_addr);
    @(negedge clk);
    op_valid = 1'b0;
    check(done && wr_en == e_wr && cy_we == e_cyw && br_taken == e_br &&
          (!e_wr || (wr_addr == e_addr && wr_data == e_data && wr_mask == m)) &&
          (!e_cyw || cy_out == e_cyv),
          tg, $sformatf("op=%0d a=%0h flags{done,wr,cyw,br}", op, a),
          {4'(0), done, wr_en, cy_we, br_taken, wr_data, wr_mask, 7'(0), cy_out},
          {4'(0), 1'b1, e_wr, e_cyw, e_br, e_data, (e_wr ? m : 8'h00), 7'(0), e_cyv});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("[TB] FAIL watchdog R3 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check(!done && !wr_en && !cy_we && !br_taken && wr_mask == 0 && wr_data == 0,
          "R11", "reset outputs", {done, wr_en, cy_we, br_taken, wr_mask}, 0);
    rst_n = 1'b1;

    // R12: op_valid low ignores op_code
    @(negedge clk);
    op_code = 4'd4; bit_addr = 8'h05; rd_byte = 8'h00; op_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!done && !wr_en && !cy_we && !br_taken, "R12", "idle outputs",
            {done, wr_en, cy_we, br_taken}, 0);
    end

    // R3: done lasts one cycle only
    run_op(4, 8'h11, 1'b0, 8'h00, 8'h00);
    @(negedge clk);
    check(!done && !wr_en, "R3", "done after one cycle", {done, wr_en}, 0);

    // directed corners named in the requirements
    run_op(4, 8'h7F, 1'b0, 8'h00, 8'h00);   // R1: byte 0x2F, bit 7
    run_op(4, 8'h17, 1'b0, 8'h00, 8'h00);   // R1: byte 0x22, bit 7
    run_op(6, 8'h93, 1'b0, 8'hF0, 8'h0F);   // R10: port byte 0x90 uses latch
    run_op(13, 8'h93, 1'b0, 8'hF0, 8'h0F);  // R10: test reads sampled value
    run_op(15, 8'hD5, 1'b1, 8'h20, 8'h20);  // R9: register byte, bit set
    run_op(15, 8'hD5, 1'b1, 8'hDF, 8'hDF);  // R9: bit clear, no write

    // sweep: every bit address, every code, both carries, two data patterns
    for (int a = 0; a < 256; a++) begin
      for (int op = 0; op < 16; op++) begin
        for (int c = 0; c < 2; c++) begin
          for (int p = 0; p < 2; p++) begin
            logic [7:0] pin, lat;
            pin = 8'(a * 37 + p * 91 + op);
            lat = ~pin ^ 8'(op * 3);
            run_op(op, a, c[0], pin, lat);
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule